// File: doc/BRIEF.md
# Handshake-Framed SPI Slave Port

This block is the slave end of a point-to-point serial link with one master and no chip select. Two readiness lines frame each transfer window instead. The master raises its ready line when it wants to move data. The slave raises its own ready line when it has a byte to send or can take one in. Bits move only while both lines are high. The serial clock idles low. The slave drives each bit after a rising edge and captures each incoming bit on a falling edge. Bytes travel most significant bit first in both directions.

All serial inputs are resynchronized into the system clock domain and sampled there, so the system clock must run well above the serial clock. On the system side, a byte-wide transmit path with valid/ready supplies outgoing bytes. A byte-wide receive path with a one-cycle strobe delivers incoming bytes. A level input tells the port that the system can accept received data. Every rising edge of the master's ready line produces a one-cycle wake pulse, whatever state the port is in. The pulse lets a sleeping system be roused.

Top module: `rdy_spi_slave`

## Requirements
- R1: After reset, `miso_o` is 1 and `dev_rdy_o`, `wake_o`, `rx_valid_o` and `tx_ready_o` are all 0.
- R2: `dev_rdy_o` rises only when `tx_valid_i` or `rx_en_i` is high. With both low it stays 0, even while `host_rdy_i` is high.
- R3: Every rising edge of `host_rdy_i` produces exactly one `wake_o` pulse, one system cycle long, whether or not a window opens.
- R4: In an open window, the port shifts in eight `mosi_i` bits on falling `sclk_i` edges, first bit received as bit 7. It then pulses `rx_valid_o` for one cycle with the byte on `rx_data_o`.
- R5: `miso_o` is 1 outside a window and before the first rising edge of a window. Inside a window it shows bit 7 of the current byte after the first rising edge, then the next lower bit after each later rising edge.
- R6: The port takes one byte from the transmit path at the first rising edge of each byte. `tx_ready_o` pulses for one cycle at that point only. If `tx_valid_i` is low then, the byte sent is 8'hFF.
- R7: Serial clock edges have no effect unless both ready lines are high: no `rx_valid_o`, no `tx_ready_o`, and `miso_o` stays 1.
- R8: After `host_rdy_i` falls, `dev_rdy_o` drops and stays low for at least one cycle. The bit count clears, so a partial byte is discarded and the next window starts at a byte boundary.
- R9: One window carries any number of back-to-back bytes. The transmit path is drained in order, and each received byte is strobed separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master, idles low |
| mosi_i | input | 1 | Serial data from the master, idles high |
| miso_o | output | 1 | Serial data to the master, idles high |
| host_rdy_i | input | 1 | Master ready line, idles low |
| dev_rdy_o | output | 1 | Slave ready line, idles low |
| wake_o | output | 1 | One-cycle pulse on each master ready rising edge |
| tx_data_i | input | DATA_W | Next byte to send |
| tx_valid_i | input | 1 | Transmit byte is available |
| tx_ready_o | output | 1 | Transmit byte taken this cycle |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_en_i | input | 1 | System can accept received bytes |

## Verification
The bench builds the port with DATA_W = 8 and SYNC_STAGES = 2, at a serial bit time of ten system cycles. This ratio keeps the full synchronizer delay, and the MISO update behind it, inside half a serial period, as a real master would see it. Directed cases cover clocking with only the master ready line high, a window aborted mid-byte, and a transmit queue that runs dry inside a window. Seeded random windows vary the byte count, the queue depth and the MOSI data, and the bench predicts every MISO and receive byte from its own queue model.

// File: rtl/rdy_spi_pkg.sv
// Shared types for the handshake-framed SPI slave port.
package rdy_spi_pkg;

    // Handshake window states: idle, offering, open window, forced gap after close.
    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_OFFER = 2'd1,
        HS_OPEN  = 2'd2,
        HS_CLOSE = 2'd3
    } hs_state_t;

endpackage

// File: rtl/rdy_spi_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is independent; per-bit reset values come from RST_VAL.
module rdy_spi_sync #(
    parameter int               WIDTH       = 3,
    parameter int               STAGES      = 2,
    parameter logic [WIDTH-1:0] RST_VAL     = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage captures the raw asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q[0] <= RST_VAL;
        end else begin
            stage_q[0] <= async_i;
        end
    end

    // Remaining stages form the metastability settling chain.
    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else begin
                    stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/rdy_spi_edge.sv
// Edge detector on already synchronized signals.
// Produces single-cycle rise and fall pulses per bit; assumes inputs reset low.
module rdy_spi_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] prev_q;

    // Hold last cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= level_i;
        end
    end

    assign rise_o = level_i & ~prev_q;
    assign fall_o = ~level_i & prev_q;

endmodule

// File: rtl/rdy_spi_handshake.sv
// Ready-line sequencer. Offers the slave ready line when the system has
// something to send or room to receive, opens a window once the master
// ready line is also high, and forces a one-cycle gap after the master
// drops its ready line. Assumes host_rdy inputs are synchronized.
module rdy_spi_handshake
    import rdy_spi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,       // tx byte pending or rx space available
    input  logic host_rdy_i,   // synchronized master ready level
    input  logic host_fall_i,  // synchronized master ready falling edge
    output logic dev_rdy_o,
    output logic window_o
);

    hs_state_t state_q, state_d;

    // Next-state selection for the window sequencer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE:  if (want_i)                      state_d = HS_OFFER;
            HS_OFFER: if (host_rdy_i)                  state_d = HS_OPEN;
            HS_OPEN:  if (host_fall_i || !host_rdy_i)  state_d = HS_CLOSE;
            HS_CLOSE:                                  state_d = HS_IDLE;
            default:                                   state_d = HS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign dev_rdy_o = (state_q == HS_OFFER) || (state_q == HS_OPEN);
    assign window_o  = (state_q == HS_OPEN);

endmodule

// File: rtl/rdy_spi_shifter.sv
// Bit engine for clock mode 1, MSB first. While the window is open, each
// rising serial edge presents the next output bit and each falling edge
// captures one input bit. The transmit byte is fetched on the first rising
// edge of each byte. Outside the window the count clears and the output idles high.
module rdy_spi_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              window_i,
    input  logic              sclk_rise_i,
    input  logic              sclk_fall_i,
    input  logic              mosi_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic              miso_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o
);

    localparam int              CNT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  bit_cnt_q;
    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic              miso_q;
    logic              fetch;
    logic [DATA_W-1:0] fetch_byte;

    // Fetch a new byte at the first rising edge of every byte slot.
    assign fetch      = window_i && sclk_rise_i && (bit_cnt_q == '0);
    assign fetch_byte = tx_valid_i ? tx_data_i : '1;
    assign tx_ready_o = fetch;

    // Bit counter: advances on falling edges, cleared outside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
        end else if (!window_i) begin
            bit_cnt_q <= '0;
        end else if (sclk_fall_i) begin
            bit_cnt_q <= (bit_cnt_q == LAST_BIT) ? '0 : bit_cnt_q + 1'b1;
        end
    end

    // Transmit shifter and output bit, updated on rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh_q <= '1;
            miso_q  <= 1'b1;
        end else if (!window_i) begin
            tx_sh_q <= '1;
            miso_q  <= 1'b1;
        end else if (fetch) begin
            miso_q  <= fetch_byte[DATA_W-1];
            tx_sh_q <= {fetch_byte[DATA_W-2:0], 1'b1};
        end else if (sclk_rise_i) begin
            miso_q  <= tx_sh_q[DATA_W-1];
            tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b1};
        end
    end

    // Receive shifter, captured on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh_q <= '0;
        end else if (window_i && sclk_fall_i) begin
            rx_sh_q <= {rx_sh_q[DATA_W-2:0], mosi_i};
        end
    end

    // Byte completion strobe and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid_o <= 1'b0;
            rx_data_o  <= '0;
        end else begin
            rx_valid_o <= 1'b0;
            if (window_i && sclk_fall_i && (bit_cnt_q == LAST_BIT)) begin
                rx_valid_o <= 1'b1;
                rx_data_o  <= {rx_sh_q[DATA_W-2:0], mosi_i};
            end
        end
    end

    assign miso_o = miso_q;

endmodule

// File: rtl/rdy_spi_slave.sv
// Top of the handshake-framed SPI slave port. Synchronizes the serial
// inputs, detects edges, sequences the ready lines and runs the bit engine.
// Assumes the system clock runs at least four times the serial clock; more
// margin is needed for MISO to settle before the master's sampling edge.
module rdy_spi_slave #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              mosi_i,
    output logic              miso_o,
    input  logic              host_rdy_i,
    output logic              dev_rdy_o,
    output logic              wake_o,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    input  logic              rx_en_i
);

    // Bit order in the synchronized bundle: [2]=mosi, [1]=host ready, [0]=sclk.
    localparam int          SYNC_W   = 3;
    localparam logic [2:0]  SYNC_RST = 3'b100;

    logic [SYNC_W-1:0] sync_lvl;
    logic [1:0]        edge_rise;
    logic [1:0]        edge_fall;
    logic              window;

    rdy_spi_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({mosi_i, host_rdy_i, sclk_i}),
        .sync_o  (sync_lvl)
    );

    rdy_spi_edge #(
        .WIDTH   (2)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sync_lvl[1:0]),
        .rise_o  (edge_rise),
        .fall_o  (edge_fall)
    );

    rdy_spi_handshake u_hs (
        .clk         (clk),
        .rst_n       (rst_n),
        .want_i      (tx_valid_i || rx_en_i),
        .host_rdy_i  (sync_lvl[1]),
        .host_fall_i (edge_fall[1]),
        .dev_rdy_o   (dev_rdy_o),
        .window_o    (window)
    );

    rdy_spi_shifter #(
        .DATA_W      (DATA_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .window_i    (window),
        .sclk_rise_i (edge_rise[0]),
        .sclk_fall_i (edge_fall[0]),
        .mosi_i      (sync_lvl[2]),
        .tx_data_i   (tx_data_i),
        .tx_valid_i  (tx_valid_i),
        .tx_ready_o  (tx_ready_o),
        .miso_o      (miso_o),
        .rx_data_o   (rx_data_o),
        .rx_valid_o  (rx_valid_o)
    );

    // Wake pulse registered from the master ready rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_o <= 1'b0;
        end else begin
            wake_o <= edge_rise[1];
        end
    end

endmodule

// File: rtl/rdy_spi_slave_chk.sv
// Property checker for the handshake-framed SPI slave port, bound to the top.
module rdy_spi_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic miso_o,
    input logic dev_rdy_o,
    input logic wake_o,
    input logic tx_valid_i,
    input logic tx_ready_o,
    input logic rx_valid_o,
    input logic rx_en_i
);

    // R2: the slave ready line only rises when there is a reason to offer.
    assert_rdy_reason_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_rdy_o) |-> $past(tx_valid_i || rx_en_i));

    // R3: wake is a single-cycle pulse.
    assert_wake_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    // R4: the receive strobe lasts one cycle.
    assert_rx_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R5: MISO idles high once the ready line has been low for two cycles.
    assert_miso_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_rdy_o && $past(!dev_rdy_o)) |-> miso_o);

    // R6: transmit fetch is a single-cycle pulse.
    assert_fetch_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |=> !tx_ready_o);

    // R7: no fetch outside an offered window.
    assert_fetch_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |-> dev_rdy_o);

    // R7: a received byte comes only from an open window.
    assert_rx_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> $past(dev_rdy_o));

    // R8: after the ready line drops it stays low for a cycle.
    assert_rdy_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_rdy_o) |=> !dev_rdy_o);

endmodule

bind rdy_spi_slave rdy_spi_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miso_o     (miso_o),
    .dev_rdy_o  (dev_rdy_o),
    .wake_o     (wake_o),
    .tx_valid_i (tx_valid_i),
    .tx_ready_o (tx_ready_o),
    .rx_valid_o (rx_valid_o),
    .rx_en_i    (rx_en_i)
);

// File: tb/rdy_spi_slave_tb.sv
`timescale 1ns/1ps
module rdy_spi_slave_tb;

    localparam int HALF = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       mosi = 1'b1;
    logic       miso;
    logic       host_rdy = 1'b0;
    logic       dev_rdy;
    logic       wake;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_en = 1'b0;

    always #2.5 clk = ~clk;

    rdy_spi_slave #(.DATA_W(8), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .mosi_i(mosi), .miso_o(miso),
        .host_rdy_i(host_rdy), .dev_rdy_o(dev_rdy), .wake_o(wake),
        .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
        .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_en_i(rx_en)
    );

    int n_run = 0, n_fail = 0;
    logic [7:0] tx_mem [0:255];
    int tx_num = 0, tx_idx = 0, mpos = 0;
    logic [7:0] rx_log [0:255];
    int rx_cnt = 0, wake_cnt = 0, fall_cnt = 0, exp_wake = 0;
    logic rdy_prev = 1'b0;

    assign tx_valid = tx_idx < tx_num;
    assign tx_data  = tx_mem[tx_idx[7:0]];

    // Monitors: transmit consumption, receive log, wake and ready-drop counts.
    always @(posedge clk) begin
        if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
        if (rx_valid) begin
            rx_log[rx_cnt[7:0]] <= rx_data;
            rx_cnt <= rx_cnt + 1;
        end
        if (wake) wake_cnt <= wake_cnt + 1;
        if (rdy_prev && !dev_rdy) fall_cnt <= fall_cnt + 1;
        rdy_prev <= dev_rdy;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_mem[tx_num[7:0]] = b;
        tx_num++;
    endtask

    // Bench model of the byte the slave must send next.
    task automatic next_exp(output logic [7:0] e);
        if (mpos < tx_num) begin
            e = tx_mem[mpos[7:0]];
            mpos++;
        end else begin
            e = 8'hFF;
        end
    endtask

    // One byte as a mode 1 master: drive on rise, sample MISO just before fall.
    task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
        for (int i = 7; i >= 0; i--) begin
            sclk = 1'b1;
            mosi = mo[i];
            tick(HALF);
            mi[i] = miso;
            sclk = 1'b0;
            tick(HALF);
        end
    endtask

    task automatic open_win();
        host_rdy = 1'b1;
        exp_wake++;
        tick(6);
    endtask

    task automatic close_win();
        host_rdy = 1'b0;
        tick(6);
    endtask

    // Run one window of nb bytes with given MOSI data and check both directions.
    task automatic run_bytes(input int nb, input logic [7:0] seed_b, input string tag);
        logic [7:0] mi, e, mo;
        int base;
        base = rx_cnt;
        for (int b = 0; b < nb; b++) begin
            mo = seed_b ^ 8'(b * 37);
            xfer(mo, mi);
            next_exp(e);
            chk(mi == e, {tag, " R5 R6 miso byte"}, mi, e);
            tick(4);
            chk(rx_cnt == base + b + 1, {tag, " R4 rx count"}, rx_cnt, base + b + 1);
            chk(rx_log[8'(base + b)] == mo, {tag, " R4 R9 rx byte"}, rx_log[8'(base + b)], mo);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        logic [7:0] mi;
        int f0, r0;
        void'($urandom(32'h5EED_1234));

        // R1: reset state.
        tick(5);
        chk(miso == 1'b1, "R1 miso", miso, 1);
        chk(dev_rdy == 1'b0 && wake == 1'b0, "R1 ready/wake", {dev_rdy, wake}, 0);
        chk(rx_valid == 1'b0 && tx_ready == 1'b0, "R1 strobes", {rx_valid, tx_ready}, 0);
        rst_n = 1'b1;
        tick(3);
        chk(dev_rdy == 1'b0, "R1 ready after release", dev_rdy, 0);

        // R2 R3 R7: master ready alone, clocking with no offer.
        open_win();
        chk(wake_cnt == exp_wake, "R3 wake on master ready", wake_cnt, exp_wake);
        chk(dev_rdy == 1'b0, "R2 no offer without reason", dev_rdy, 0);
        xfer(8'h5A, mi);
        tick(4);
        chk(rx_cnt == 0, "R7 no rx outside window", rx_cnt, 0);
        chk(mi == 8'hFF, "R7 miso idle outside window", mi, 8'hFF);
        close_win();

        // R2 R4 R6: receive-only window, empty transmit queue.
        rx_en = 1'b1;
        tick(4);
        chk(dev_rdy == 1'b1, "R2 offer on rx space", dev_rdy, 1);
        open_win();
        chk(wake_cnt == exp_wake, "R3 wake second rise", wake_cnt, exp_wake);
        chk(miso == 1'b1, "R5 miso high before first edge", miso, 1);
        run_bytes(1, 8'hA5, "directed rx");
        rx_en = 1'b0;
        close_win();
        chk(dev_rdy == 1'b0, "R8 ready drops after close", dev_rdy, 0);

        // R8: abort mid-byte, then a clean byte must not be polluted.
        rx_en = 1'b1;
        tick(4);
        open_win();
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b1; mosi = 1'b0; tick(HALF);
            sclk = 1'b0; tick(HALF);
        end
        mosi = 1'b1;
        f0 = fall_cnt;
        r0 = rx_cnt;
        close_win();
        chk(fall_cnt == f0 + 1, "R8 ready dropped on abort", fall_cnt, f0 + 1);
        chk(rx_cnt == r0, "R8 partial byte discarded", rx_cnt, r0);
        open_win();
        run_bytes(1, 8'h3C, "after abort");
        rx_en = 1'b0;
        close_win();

        // R2 R9: transmit-only offer, queue drains mid-window then all ones.
        push_tx(8'h81); push_tx(8'h7E); push_tx(8'hC3);
        tick(4);
        chk(dev_rdy == 1'b1, "R2 offer on tx pending", dev_rdy, 1);
        open_win();
        run_bytes(4, 8'h96, "multi byte");
        close_win();
        chk(dev_rdy == 1'b0, "R8 ready low after drain", dev_rdy, 0);
        chk(tx_idx == 3, "R6 R9 tx bytes consumed", tx_idx, 3);

        // Random windows: queue depth, byte count and data vary.
        for (int w = 0; w < 16; w++) begin
            int add, nb;
            add = $urandom_range(0, 3);
            for (int k = 0; k < add; k++) push_tx(8'($urandom));
            nb = $urandom_range(1, 4);
            rx_en = 1'b1;
            tick(4);
            open_win();
            chk(miso == 1'b1, "R5 random idle high", miso, 1);
            run_bytes(nb, 8'($urandom), "random");
            rx_en = 1'b0;
            close_win();
            chk(tx_idx == mpos, "R6 random consumption", tx_idx, mpos);
        end

        chk(wake_cnt == exp_wake, "R3 total wake pulses", wake_cnt, exp_wake);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule